// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-programmed SPI master that sends one serial-flash command at a time. Software writes a command byte, a three-bit capture selector and a chip-select hold flag into the control word. A 1 written to the top bit of that word starts a transfer. The engine then drives SPI mode 0 signals. It sends the command byte, then the three low address bytes, then zero filler bytes. It keeps the received bytes that the capture selector asks for and places them in a read-only result word.

In the normal mode the engine clocks only as many bytes as the selector needs, and then it releases chip select. In hold mode each start shifts exactly one byte, which is the command byte. Chip select stays asserted between starts, so software can build a transfer of any length one byte at a time. It reads each received byte from the result word. A later control write with the hold flag clear releases chip select.

Top module: `sflash_ctrl`

## Requirements
- R1: After reset the control, address and result words read 0, `spi_cs_n` is 1 and `spi_sck` is 0.
- R2: The control word is at byte offset 0x00, the address word at 0x04 and the result word at 0x08. Control holds the command byte in bits [7:0], the selector in bits [10:8] and the hold flag in bit 12, and these read back as written. Bit 31 reads the busy state. Writes to the result word have no effect.
- R3: A control write with bit 31 set while idle starts a transfer. Bit 31 then reads 1 until the last byte ends, and reads 0 afterwards.
- R4: Bytes are sent MSB first. Byte 1 is the command byte. Bytes 2, 3 and 4 are address bits [23:16], [15:8] and [7:0]. Every later byte is 0x00. MOSI changes only while SCK is low.
- R5: Without hold, selectors 0, 1, 6, 2, 3, 4, 7 and 5 clock 1, 2, 3, 4, 5, 8, 9 and 12 bytes respectively, with chip select low throughout. Chip select returns high when the transfer ends.
- R6: Selectors 0, 1, 6, 2 and 3 put received byte 1, 2, 3, 4 and 5 respectively into result bits [7:0], with the upper bits zero.
- R7: Selectors 4, 7 and 5 put received bytes 5–8, 6–9 and 9–12 respectively into the result word. The earliest byte of the window goes to bits [7:0] and the latest to bits [31:24].
- R8: Writes to the control or address word while busy have no effect.
- R9: With the hold flag set, a start shifts only the command byte. Chip select stays low after the byte, and the received byte goes zero-extended into the result word.
- R10: An idle control write with the hold flag clear releases a held chip select.
- R11: One SCK period lasts DIV clock cycles (default 4). MISO is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
A responder model returns a distinct value for every byte position of a chip-select period, so each selector is tried and the captured word shows which positions were kept and in which order. Only a correct window placement and reversal gives the expected word. The SCK edge count per transfer tells a wrong byte count apart from a wrong capture. The MOSI bytes recorded over a 12-byte transfer confirm the order of command, address and filler. A three-start hold sequence shows that chip select persists and that the responder's position keeps advancing across starts. Writes issued mid-transfer then check that the transfer carries on unchanged.

// File: rtl/sflash_ctrl.sv
`timescale 1ns/1ps
module sflash_ctrl #(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [7:0]    opcode_q;
  logic [2:0]    action_q;
  logic          hold_q;
  logic [31:0]   addr_q, data_q, win_q;
  logic          busy, held;
  logic [CW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [3:0]    byte_no, total;
  logic [7:0]    tx_sh, rx_sh, next_tx;
  logic          wide;

  wire sel_ctrl = bus_addr[3:2] == 2'd0;
  wire sel_addr = bus_addr[3:2] == 2'd1;
  wire tick_mid = div_cnt == CW'(HALF - 1);
  wire tick_end = div_cnt == CW'(DIV - 1);

  assign spi_sck  = busy && (div_cnt >= CW'(HALF));
  assign spi_mosi = tx_sh[7];
  assign spi_cs_n = !(busy || held);
  assign wide     = !hold_q && (action_q == 3'd4 || action_q == 3'd5 || action_q == 3'd7);

  always_comb begin
    case (bus_addr[3:2])
      2'd0:    bus_rdata = {busy, 18'd0, hold_q, 1'b0, action_q, opcode_q};
      2'd1:    bus_rdata = addr_q;
      2'd2:    bus_rdata = data_q;
      default: bus_rdata = 32'd0;
    endcase
  end

  always_comb begin
    if (hold_q) total = 4'd1;
    else begin
      case (action_q)
        3'd0: total = 4'd1;
        3'd1: total = 4'd2;
        3'd6: total = 4'd3;
        3'd2: total = 4'd4;
        3'd3: total = 4'd5;
        3'd4: total = 4'd8;
        3'd7: total = 4'd9;
        default: total = 4'd12;
      endcase
    end
  end

  always_comb begin
    case (byte_no)
      4'd1:    next_tx = addr_q[23:16];
      4'd2:    next_tx = addr_q[15:8];
      4'd3:    next_tx = addr_q[7:0];
      default: next_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opcode_q <= '0;
      action_q <= '0;
      hold_q   <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      win_q    <= '0;
      busy     <= 1'b0;
      held     <= 1'b0;
      div_cnt  <= '0;
      bit_cnt  <= '0;
      byte_no  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else begin
      if (bus_we && !busy) begin
        if (sel_ctrl) begin
          opcode_q <= bus_wdata[7:0];
          action_q <= bus_wdata[10:8];
          hold_q   <= bus_wdata[12];
          if (!bus_wdata[12]) held <= 1'b0;
          if (bus_wdata[31]) begin
            busy    <= 1'b1;
            div_cnt <= '0;
            bit_cnt <= '0;
            byte_no <= 4'd1;
            tx_sh   <= bus_wdata[7:0];
          end
        end
        if (sel_addr) addr_q <= bus_wdata;
      end
      if (busy) begin
        div_cnt <= tick_end ? '0 : div_cnt + 1'b1;
        if (tick_mid) rx_sh <= {rx_sh[6:0], spi_miso};
        if (tick_end) begin
          if (bit_cnt == 3'd7) begin
            bit_cnt <= '0;
            win_q   <= {rx_sh, win_q[31:8]};
            if (byte_no == total) begin
              busy   <= 1'b0;
              held   <= hold_q;
              data_q <= wide ? {rx_sh, win_q[31:8]} : {24'd0, rx_sh};
            end else begin
              byte_no <= byte_no + 4'd1;
              tx_sh   <= next_tx;
            end
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            tx_sh   <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel_ctrl && bus_wdata[31] && !busy) |=> busy);

  p_ctrl_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel_ctrl && busy) |=> ($stable(opcode_q) && $stable(action_q) && $stable(hold_q)));

  p_addr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel_addr && busy) |=> $stable(addr_q));

  p_mosi_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  p_hold_keeps_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && hold_q) |-> !spi_cs_n);

  p_release_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !hold_q) |-> spi_cs_n);

  p_byte_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (byte_no != 4'd0 && byte_no <= total));
endmodule

// File: tb/tb_sflash_ctrl.sv
`timescale 1ns/1ps
module tb_sflash_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  int errors = 0;
  int checks = 0;
  int bitpos = 0;
  int nedge  = 0;
  logic [7:0] cur_mo = 8'd0;
  logic [7:0] mo_bytes [0:15];
  time t_last = 0;
  time t_period = 0;

  always #2 clk = ~clk;

  sflash_ctrl #(.DIV(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  always @(negedge spi_cs_n) begin
    bitpos = 0;
    spi_miso = pat(1)[7];
  end

  always @(posedge spi_sck) begin
    cur_mo = {cur_mo[6:0], spi_mosi};
    bitpos = bitpos + 1;
    if (bitpos % 8 == 0 && bitpos / 8 < 16) mo_bytes[bitpos / 8] = cur_mo;
    nedge = nedge + 1;
    t_period = $time - t_last;
    t_last = $time;
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n) spi_miso = pat(bitpos / 8 + 1)[7 - (bitpos % 8)];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(4'h0, v);
      if (!v[31]) return;
    end
    chk("R3 busy timeout", 32'd1, 32'd0);
  endtask

  function automatic int nbytes(input int act);
    case (act)
      0: return 1; 1: return 2; 6: return 3; 2: return 4;
      3: return 5; 4: return 8; 7: return 9; default: return 12;
    endcase
  endfunction

  function automatic logic [31:0] expect_data(input int act);
    int n = nbytes(act);
    if (act == 4 || act == 5 || act == 7)
      return {pat(n), pat(n - 1), pat(n - 2), pat(n - 3)};
    return {24'd0, pat(n)};
  endfunction

  task automatic test_reset();
    logic [31:0] v;
    rd(4'h0, v); chk("R1 ctrl reset", v, 32'd0);
    rd(4'h4, v); chk("R1 addr reset", v, 32'd0);
    rd(4'h8, v); chk("R1 data reset", v, 32'd0);
    chk("R1 cs idle", {31'd0, spi_cs_n}, 32'd1);
    chk("R1 sck idle", {31'd0, spi_sck}, 32'd0);
  endtask

  task automatic test_action(input int act, input logic [7:0] op);
    logic [31:0] v;
    nedge = 0;
    wr(4'h0, 32'h8000_0000 | (32'(act) << 8) | 32'(op));
    rd(4'h0, v); chk("R3 busy while running", {31'd0, v[31]}, 32'd1);
    wait_idle();
    chk("R5 byte count", 32'(nedge), 32'(nbytes(act) * 8));
    chk("R5 cs released", {31'd0, spi_cs_n}, 32'd1);
    rd(4'h8, v);
    if (act == 4 || act == 5 || act == 7) chk("R7 window capture", v, expect_data(act));
    else chk("R6 single capture", v, expect_data(act));
    chk("R4 opcode byte", {24'd0, mo_bytes[1]}, {24'd0, op});
    rd(4'h0, v); chk("R2 ctrl readback", v, {19'd0, 1'b0, 1'b0, 3'(act), op});
  endtask

  task automatic test_frame();
    logic [7:0] orv;
    logic [31:0] v;
    wr(4'h4, 32'h00C3_5A17);
    rd(4'h4, v); chk("R2 addr readback", v, 32'h00C3_5A17);
    test_action(5, 8'h0B);
    chk("R4 cmd+addr bytes", {mo_bytes[1], mo_bytes[2], mo_bytes[3], mo_bytes[4]}, 32'h0BC3_5A17);
    orv = 8'd0;
    for (int i = 5; i <= 12; i++) orv = orv | mo_bytes[i];
    chk("R4 filler bytes zero", {24'd0, orv}, 32'd0);
    chk("R11 sck period ns", 32'(t_period), 32'd16);
  endtask

  task automatic test_busy_writes();
    logic [31:0] v;
    wr(4'h0, 32'h8000_0403);
    wr(4'h0, 32'h8000_10EE);
    wr(4'h4, 32'h0011_2233);
    rd(4'h0, v); chk("R8 ctrl write ignored", v[30:0], 31'h0000_0403);
    wait_idle();
    rd(4'h0, v); chk("R8 ctrl after done", v, 32'h0000_0403);
    rd(4'h4, v); chk("R8 addr write ignored", v, 32'h00C3_5A17);
    rd(4'h8, v); chk("R7 capture intact", v, expect_data(4));
    wr(4'h8, 32'hDEAD_BEEF);
    rd(4'h8, v); chk("R2 data read-only", v, expect_data(4));
  endtask

  task automatic test_hold();
    logic [31:0] v;
    logic [7:0] ops [0:2];
    ops[0] = 8'h9F; ops[1] = 8'h3C; ops[2] = 8'hA5;
    for (int i = 0; i < 3; i++) begin
      nedge = 0;
      wr(4'h0, 32'h8000_1500 | 32'(ops[i]));
      wait_idle();
      chk("R9 one byte per start", 32'(nedge), 32'd8);
      chk("R9 cs held", {31'd0, spi_cs_n}, 32'd0);
      rd(4'h8, v); chk("R9 byte capture", v, {24'd0, pat(i + 1)});
      chk("R9 opcode sent", {24'd0, mo_bytes[i + 1]}, {24'd0, ops[i]});
    end
    repeat (8) @(negedge clk);
    chk("R9 cs still held idle", {31'd0, spi_cs_n}, 32'd0);
    wr(4'h0, 32'h0000_0000);
    @(negedge clk);
    chk("R10 cs released", {31'd0, spi_cs_n}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    wr(4'h4, 32'h0012_3456);
    test_action(0, 8'h05);
    test_action(1, 8'h06);
    test_action(6, 8'h07);
    test_action(2, 8'h08);
    test_action(3, 8'h09);
    test_action(4, 8'h0A);
    test_action(7, 8'h0C);
    test_frame();
    test_busy_writes();
    test_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule